// File: doc/BRIEF.md
# Programmable clock output generator

This block produces one clock output from a choice of eight power-of-two divisions of the main clock or from an unrelated low-frequency subsystem clock. A one-byte control register on a simple write port selects the source and switches the output on or off. Software can update the whole byte or one bit at a time. The output is always a register. It is never gated combinationally, so it cannot glitch.

The block runs on `clk`, which is taken to run at twice the nominal main-clock rate. Select code n toggles the output every 2^n `clk` cycles. Code 0 therefore gives the main clock itself, and code 7 gives the main clock divided by 128. Code 8 passes the subsystem clock through a synchronizer. Codes 9 to 15 are not allowed. If one of them is written while the output is enabled, the output stays off and a sticky error flag is raised.

Starting and stopping follow fixed rules. The source selection is captured only when the output starts, and it is held until the output stops. Turning the output off never cuts a high phase short.

Top module: `clkout_gen`

## Requirements
- R1: After reset, `bus_rdata` reads 00h, `clk_out` is low and `err_flag` is low.
- R2: A byte write stores `bus_wdata[4]` as the enable bit and `bus_wdata[3:0]` as the select code. `bus_rdata` always shows {000, enable, select}, so bits 7..5 read 0.
- R3: A single-bit write with index 0..4 changes only that bit: bit 4 is the enable, bits 3..0 are the select. Indices 5..7 change nothing. If a byte write and a bit write occur in the same cycle, the byte write wins.
- R4: While the output is not running, `clk_out` is low and the divider counter is held at zero.
- R5: With a running select code n (0..7), `clk_out` is high for 2^n cycles and then low for 2^n cycles, repeating.
- R6: Take the clock edge that stores an enable of 1 with a legal code. On the next edge the captured divided output goes high, with the counter starting from zero. For code 8, the output waits for the next rising edge of the synchronized subsystem clock.
- R7: When the enable is cleared while `clk_out` is high, the current high phase runs to its full length and then `clk_out` goes low and stays low.
- R8: With code 8 running, `clk_out` follows the subsystem clock after a two-stage synchronizer plus one output register.
- R9: Enable set together with a code of 9..15 acts as disabled and sets `err_flag`. `err_flag` stays set until reset.
- R10: Changing the select code while running has no effect on `clk_out`. The new code is applied only when the output starts again after having stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock, twice the main-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_clk | input | 1 | Subsystem clock, asynchronous to `clk` |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_bwr | input | 1 | Single-bit write strobe |
| bus_bidx | input | 3 | Bit index for the single-bit write |
| bus_bval | input | 1 | Value for the single-bit write |
| bus_rdata | output | 8 | Control register readback |
| err_flag | output | 1 | Sticky forbidden-code flag |
| clk_out | output | 1 | Generated clock output |

## Verification
The hardest state to reach is a disable or a code change that lands in the middle of a long high phase. That case decides whether a runt pulse or a glitch can appear. The stimulus watches `clk_out` and issues the disable write a few cycles into a 16-cycle high phase. It also rewrites the select code while the output is running, and then confirms that the measured high-phase length stays unchanged. The subsystem path is run against a bench clock whose edges keep a fixed offset from `clk`, so the synchronizer delay can be predicted exactly.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  localparam int SEL_W  = 4;
  localparam int EN_BIT = 4;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } clkout_ctl_t;

  // legal select: divided codes and the subsystem code
  function automatic logic sel_is_legal(logic [SEL_W-1:0] s, logic [SEL_W-1:0] sub_code);
    return s <= sub_code;
  endfunction

  // code beyond the subsystem code is forbidden
  function automatic logic sel_is_forbidden(logic [SEL_W-1:0] s, logic [SEL_W-1:0] sub_code);
    return s > sub_code;
  endfunction

endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int SUB_CODE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [EN_BIT:0]  wdata_lo,
  input  logic             bus_bwr,
  input  logic [2:0]       bus_bidx,
  input  logic             bus_bval,
  output clkout_ctl_t      ctl,
  output logic [7:0]       rdata,
  output logic             err
);

  localparam logic [SEL_W-1:0] SUB_SEL = SEL_W'(SUB_CODE);

  clkout_ctl_t ctl_q;
  logic        err_q;
  logic        forbid_w;

  assign forbid_w = ctl_q.en && sel_is_forbidden(ctl_q.sel, SUB_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (bus_wr) begin
      ctl_q.en  <= wdata_lo[EN_BIT];
      ctl_q.sel <= wdata_lo[SEL_W-1:0];
    end else if (bus_bwr) begin
      case (bus_bidx)
        3'd0: ctl_q.sel[0] <= bus_bval;
        3'd1: ctl_q.sel[1] <= bus_bval;
        3'd2: ctl_q.sel[2] <= bus_bval;
        3'd3: ctl_q.sel[3] <= bus_bval;
        3'd4: ctl_q.en     <= bus_bval;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | forbid_w;
  end

  assign ctl   = ctl_q;
  assign rdata = {3'b000, ctl_q.en, ctl_q.sel};
  assign err   = err_q;

endmodule

// File: rtl/clkout_div.sv
module clkout_div #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] lim,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == lim);

endmodule

// File: rtl/clkout_sync.sv
module clkout_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic lvl_prev
);

  logic [STAGES-1:0] ff_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      ff_q   <= {ff_q[STAGES-2:0], async_in};
      prev_q <= ff_q[STAGES-1];
    end
  end

  assign lvl      = ff_q[STAGES-1];
  assign lvl_prev = prev_q;

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int DIV_STAGES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_clk,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_bwr,
  input  logic [2:0] bus_bidx,
  input  logic       bus_bval,
  output logic [7:0] bus_rdata,
  output logic       err_flag,
  output logic       clk_out
);

  localparam int               CNT_W   = DIV_STAGES - 1;
  localparam logic [SEL_W-1:0] SUB_SEL = SEL_W'(DIV_STAGES);

  // half-period limit for divided code c: 2^c - 1
  function automatic logic [CNT_W-1:0] half_limit(logic [SEL_W-1:0] c);
    logic [CNT_W-1:0] r;
    r = '0;
    for (int i = 0; i < CNT_W; i++) r[i] = (i < int'(c));
    return r;
  endfunction

  clkout_ctl_t      ctl;
  logic             run_q, out_q;
  logic [SEL_W-1:0] act_q;
  logic             sub_lvl, sub_prev;
  logic             div_hit, div_clr;
  logic             sub_mode, req_w, tgl_w, nxt_w, start_w, stop_w;
  logic [CNT_W-1:0] lim_w;

  clkout_regs #(.SUB_CODE(DIV_STAGES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .wdata_lo (bus_wdata[EN_BIT:0]),
    .bus_bwr  (bus_bwr),
    .bus_bidx (bus_bidx),
    .bus_bval (bus_bval),
    .ctl      (ctl),
    .rdata    (bus_rdata),
    .err      (err_flag)
  );

  clkout_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sub_clk),
    .lvl      (sub_lvl),
    .lvl_prev (sub_prev)
  );

  assign lim_w = half_limit(act_q);

  clkout_div #(.CNT_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (div_clr),
    .lim   (lim_w),
    .hit   (div_hit)
  );

  // named events for the checker
  assign sub_mode = (act_q == SUB_SEL);
  assign req_w    = ctl.en && sel_is_legal(ctl.sel, SUB_SEL);
  assign tgl_w    = run_q && !sub_mode && div_hit;
  assign nxt_w    = sub_mode ? (out_q ? sub_lvl : (sub_lvl & ~sub_prev))
                             : (out_q ^ tgl_w);
  assign start_w  = !run_q && req_w;
  assign stop_w   = run_q && !req_w && !nxt_w;
  assign div_clr  = !run_q || stop_w || sub_mode || tgl_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      out_q <= 1'b0;
      act_q <= '0;
    end else if (start_w) begin
      run_q <= 1'b1;
      act_q <= ctl.sel;
      out_q <= (ctl.sel != SUB_SEL);
    end else if (stop_w) begin
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else if (run_q) begin
      out_q <= nxt_w;
    end
  end

  assign clk_out = out_q;

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk #(
  parameter int SUB_CODE = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_out,
  input logic [7:0] bus_rdata,
  input logic       err_flag,
  input logic       run,
  input logic [3:0] act,
  input logic       tgl,
  input logic       en,
  input logic [3:0] sel
);

  localparam logic [3:0] SUB_SEL = 4'(SUB_CODE);

  p_rd_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:5] == 3'b000);

  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !clk_out);

  p_start_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run) && act != SUB_SEL) |-> clk_out);

  p_no_runt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act != SUB_SEL && clk_out && !tgl) |=> clk_out);

  p_forbid_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel > SUB_SEL) |=> err_flag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  p_forbid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel > SUB_SEL && !run) |=> !run);

  p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (!run || $stable(act)));

endmodule

bind clkout_gen clkout_gen_chk #(.SUB_CODE(DIV_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_out   (clk_out),
  .bus_rdata (bus_rdata),
  .err_flag  (err_flag),
  .run       (run_q),
  .act       (act_q),
  .tgl       (tgl_w),
  .en        (ctl.en),
  .sel       (ctl.sel)
);

// File: tb/test_clkout_gen.sv
module test_clkout_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub_clk = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_bwr = 1'b0;
  logic [2:0] bus_bidx = '0;
  logic       bus_bval = 1'b0;
  logic [7:0] bus_rdata;
  logic       err_flag;
  logic       clk_out;

  int n_chk = 0;
  int n_err = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  clkout_gen i_clkout_gen (
    .clk(clk), .rst_n(rst_n), .sub_clk(sub_clk),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_bwr(bus_bwr), .bus_bidx(bus_bidx), .bus_bval(bus_bval),
    .bus_rdata(bus_rdata), .err_flag(err_flag), .clk_out(clk_out)
  );

  always #5 clk = ~clk;
  // subsystem clock: edges at 2 ns past a multiple of 10, away from clk edges
  initial begin
    #2;
    forever #150 sub_clk = ~sub_clk;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_en, m_sel, m_run, m_act, m_out, m_cnt, m_err;
  bit hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_sel = 0; m_run = 0; m_act = 0; m_out = 0; m_cnt = 0; m_err = 0;
      hist = '{0, 0, 0};
    end else begin
      int s_now, s_old, ok, tick, nxt;
      s_now = hist[1];
      s_old = hist[2];
      ok    = (m_en != 0) && (m_sel <= 8);
      tick  = (m_run != 0) && (m_act < 8) && (m_cnt == (1 << m_act) - 1);
      if (m_act == 8) nxt = m_out ? s_now : (s_now && !s_old);
      else            nxt = m_out ^ tick;
      if (m_en != 0 && m_sel > 8) m_err = 1;
      if (m_run == 0) begin
        m_cnt = 0;
        if (ok) begin
          m_run = 1; m_act = m_sel; m_out = (m_sel != 8); 
        end
      end else if (!ok && nxt == 0) begin
        m_run = 0; m_out = 0; m_cnt = 0;
      end else begin
        m_out = nxt;
        m_cnt = (tick || m_act == 8) ? 0 : m_cnt + 1;
      end
      if (bus_wr) begin
        m_en = bus_wdata[4]; m_sel = bus_wdata[3:0];
      end else if (bus_bwr) begin
        if (bus_bidx == 4) m_en = bus_bval;
        else if (bus_bidx < 4) m_sel[bus_bidx] = bus_bval;
      end
      hist.push_front(sub_clk);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(tag, clk_out, m_out);
      check("R2", bus_rdata, (m_en << 4) | m_sel);
      check("R9", err_flag, m_err);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic wr_bit(input int idx, input logic v);
    @(negedge clk); bus_bwr = 1'b1; bus_bidx = 3'(idx); bus_bval = v;
    @(negedge clk); bus_bwr = 1'b0;
  endtask

  task automatic wait_level(input logic v);
    for (int i = 0; i < 1000 && clk_out != v; i++) @(negedge clk);
  endtask

  task automatic run_len(input logic v, output int n);
    n = 0;
    while (clk_out == v && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic stop_out();
    wr_byte(8'h00);
    wait_level(1'b0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int hl, ll, rises;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", bus_rdata, 0);
    check("R1", clk_out, 0);
    check("R1", err_flag, 0);
    cmp_on = 1'b1;

    // R2 byte write, upper bits dropped, output off
    tag = "R4";
    wr_byte(8'hE3);
    check("R2", bus_rdata, 8'h03);
    repeat (20) @(negedge clk);
    check("R4", clk_out, 0);

    // R3 single-bit writes
    wr_bit(2, 1'b1);
    check("R3", bus_rdata, 8'h07);
    wr_bit(6, 1'b1);
    check("R3", bus_rdata, 8'h07);
    wr_bit(0, 1'b0);
    check("R3", bus_rdata, 8'h06);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = 8'h01; bus_bwr = 1'b1; bus_bidx = 3'd3; bus_bval = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_bwr = 1'b0;
    check("R3", bus_rdata, 8'h01);

    // R6 start timing and R5 periods
    tag = "R6";
    wr_byte(8'h12);
    check("R6", clk_out, 0);
    @(negedge clk);
    check("R6", clk_out, 1);
    tag = "R5";
    run_len(1'b1, hl);
    check("R6", hl, 4);
    stop_out();
    for (int c = 0; c < 8; c += 3) begin
      wr_byte(8'h10 | 8'(c));
      wait_level(1'b1);
      run_len(1'b1, hl);
      run_len(1'b0, ll);
      check("R5", hl, 1 << c);
      check("R5", ll, 1 << c);
      stop_out();
    end
    wr_byte(8'h17);
    wait_level(1'b1); run_len(1'b1, hl); run_len(1'b0, ll);
    check("R5", hl, 128);
    check("R5", ll, 128);
    stop_out();

    // R7 disable mid high phase: full 16-cycle high phase
    tag = "R7";
    wr_byte(8'h14);
    wait_level(1'b1);
    repeat (3) @(negedge clk);
    wr_byte(8'h04);
    run_len(1'b1, hl);
    check("R7", hl + 5, 16);
    repeat (40) @(negedge clk);
    check("R7", clk_out, 0);

    // R10 select change while running is ignored
    tag = "R10";
    wr_byte(8'h11);
    wait_level(1'b1);
    wr_byte(8'h13);
    wait_level(1'b0); wait_level(1'b1);
    run_len(1'b1, hl);
    check("R10", hl, 2);
    wr_byte(8'h03);
    wait_level(1'b0);
    repeat (3) @(negedge clk);
    wr_bit(4, 1'b1);
    wait_level(1'b1);
    run_len(1'b1, hl);
    check("R10", hl, 8);
    stop_out();

    // R8 subsystem clock passthrough
    tag = "R8";
    wr_byte(8'h18);
    rises = 0;
    for (int i = 0; i < 700; i++) begin
      logic prev;
      prev = clk_out;
      @(negedge clk);
      if (clk_out && !prev) rises++;
    end
    check("R8", (rises >= 2) ? 1 : 0, 1);
    stop_out();

    // R9 forbidden codes
    tag = "R9";
    wr_byte(8'h19);
    repeat (10) @(negedge clk);
    check("R9", clk_out, 0);
    check("R9", err_flag, 1);
    wr_byte(8'h00);
    repeat (5) @(negedge clk);
    check("R9", err_flag, 1);
    wr_byte(8'h12);
    wait_level(1'b1);
    wr_byte(8'h1A);
    repeat (30) @(negedge clk);
    check("R9", clk_out, 0);
    check("R9", err_flag, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule